// File: doc/BRIEF.md
# Line Sensor Drive Timing Generator

This block produces the drive and framing signals for a linear image sensor, timed off a pixel-rate clock enable and a line sync. One generator serves two sensor families. In CCD mode it drives a transfer-gate pulse and a complementary pair of half-rate phase clocks. In contact or photoconductive mode the same pins carry a start pulse, issued once per line, and a full-rate sensor clock. Two reset-clock pins serve either two interleaved channel resets or a reset clock with a separate sample pulse. The mode bit that selects between these two uses is independent of the sensor family.

A pixel counter restarts at each line sync and runs on the pixel enable. Programmable start and end counts place three windows on the line: an offset-clamp sample window, a gain-adjust window and a free user window. A 2-bit selector routes one of them to a shared sensor-timing pin. The user window can be qualified by the line-valid flag, which is captured at the line sync. Every output comes from a flip-flop, so no pin can glitch.

Top module: `lstg_line_timer`

## Requirements
- R1: While `rst` is high at a clock edge, every output is low after that edge.
- R2: A clock edge with `pix_en` and `line_sync` both high sets the pixel count to 0. Any other edge with `pix_en` high adds one to the count. The count holds at its all-ones maximum, and it holds on edges without `pix_en`. After reset, the count sits at that maximum until the first sync.
- R3: After each clock edge, `clamp_o`, `gain_o` and the user window are high exactly when the pixel count held before that edge is at least the window's begin and below its end. A window whose begin equals its end never asserts.
- R4: In CCD mode (`ccd_mode`=1), `xfer_o` is high for counts below `xfer_len`, with the same one-edge delay. `xfer_len`=0 gives no pulse.
- R5: In contact mode (`ccd_mode`=0), `xfer_o` is high only for count 0, so it gives one pulse per line. The count saturates rather than wraps, so the pulse does not repeat.
- R6: In CCD mode, `phi1_o` and `phi2_o` are complementary. `phi1_o` is low for even pixels of a line, counted from 0 at the sync, so it toggles on every pixel enable.
- R7: In contact mode, `phi1_o` and `phi2_o` both go high for the single clock cycle that starts two edges after an edge with `pix_en` high.
- R8: With `reset_serial`=0, `rclk1_o` gives that one-cycle pulse for even pixels and `rclk2_o` gives it for odd pixels.
- R9: With `reset_serial`=1, `rclk1_o` gives the one-cycle pulse for every pixel. `rclk2_o` gives the same pulse one clock cycle later, as the sample pulse.
- R10: `sen_tim_o` follows `tim_sel`: 2'b00 selects the clamp window, 2'b01 the gain window, 2'b10 the user window on every line, and 2'b11 the user window on valid lines only.
- R11: `line_valid` is captured only at a sync edge. With `tim_sel`=2'b11 on a line that was captured as not valid, `sen_tim_o` stays low, even if `line_valid` rises later in that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel clock enable, one cycle per pixel |
| line_sync | input | 1 | Line start, acted on together with `pix_en` |
| line_valid | input | 1 | Line-valid flag, captured at the sync |
| ccd_mode | input | 1 | 1 = CCD drive, 0 = contact/photoconductive drive |
| reset_serial | input | 1 | 1 = reset clock plus sample pulse, 0 = two channel resets |
| tim_sel | input | 2 | Source select for `sen_tim_o` |
| xfer_len | input | CNT_W | Transfer-gate width in pixels (CCD mode) |
| clamp_begin | input | CNT_W | First pixel of the clamp window |
| clamp_end | input | CNT_W | Pixel just past the clamp window |
| gain_begin | input | CNT_W | First pixel of the gain window |
| gain_end | input | CNT_W | Pixel just past the gain window |
| user_begin | input | CNT_W | First pixel of the user window |
| user_end | input | CNT_W | Pixel just past the user window |
| xfer_o | output | 1 | Transfer-gate pulse or start pulse |
| phi1_o | output | 1 | Phase clock 1 or sensor clock |
| phi2_o | output | 1 | Phase clock 2 or sensor clock |
| rclk1_o | output | 1 | Reset clock 1 |
| rclk2_o | output | 1 | Reset clock 2 or sample pulse |
| clamp_o | output | 1 | High while the offset is sampled |
| gain_o | output | 1 | High while the gain may be adjusted |
| sen_tim_o | output | 1 | Selected timing window |

## Verification
The bench runs lines long enough to drive the counter into saturation. A design that wrapped instead would repeat the contact start pulse and reopen windows late in the line. It steps `pix_en` in irregular patterns, which exposes a counter or phase toggle that advances without the enable, and sensor and reset pulses that stay high longer than one cycle or arrive at the wrong edge. Window edges are checked pixel by pixel, including a zero-width window and a zero transfer length, where an off-by-one comparison shows as a window one pixel early or late. The valid-only selection is run with `line_valid` flipping mid-line, which catches a design that reads the live flag rather than the one captured at the sync.

// File: rtl/lstg_pkg.sv
package lstg_pkg;

    // Encoding of the sensor-timing output selector.
    typedef enum logic [1:0] {
        TS_CLAMP      = 2'b00,
        TS_GAIN       = 2'b01,
        TS_USER_ALL   = 2'b10,
        TS_USER_VALID = 2'b11
    } tsel_e;

    // Window indices in the comparator bank.
    localparam int WIN_CLAMP = 0;
    localparam int WIN_GAIN  = 1;
    localparam int WIN_USER  = 2;
    localparam int NUM_WIN   = 3;

    // Registered pin image of the generator.
    typedef struct packed {
        logic xfer;
        logic phi1;
        logic phi2;
        logic rclk1;
        logic rclk2;
        logic clamp;
        logic gain;
        logic sen;
    } drive_t;

    function automatic logic pick_timing(input tsel_e sel, input logic clamp,
                                         input logic gain, input logic user,
                                         input logic valid);
        case (sel)
            TS_CLAMP:    return clamp;
            TS_GAIN:     return gain;
            TS_USER_ALL: return user;
            default:     return user & valid;
        endcase
    endfunction

endpackage

// File: rtl/lstg_pix_cnt.sv
module lstg_pix_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic             line_sync,
    input  logic             line_valid,
    output logic [CNT_W-1:0] cnt,
    output logic             phase,
    output logic             stb1,
    output logic             stb2,
    output logic             vld,
    output logic             armed
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= CNT_MAX;
            phase <= 1'b0;
            stb1  <= 1'b0;
            stb2  <= 1'b0;
            vld   <= 1'b0;
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
            stb1  <= pix_en;
            stb2  <= stb1;
            if (pix_en) begin
                if (line_sync) begin
                    cnt   <= '0;
                    phase <= 1'b0;
                    vld   <= line_valid;
                end else begin
                    if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                    phase <= ~phase;
                end
            end
        end
    end

    // R2: count advances by one per pixel enable below the maximum
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !line_sync && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

    // R2: count holds at the maximum
    p_cnt_sat_r2: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !line_sync && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    // R2: no movement without a pixel enable
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!pix_en) |=> $stable(cnt));

endmodule

// File: rtl/lstg_win_bank.sv
module lstg_win_bank #(
    parameter int CNT_W = 12,
    parameter int NWIN  = 3
) (
    input  logic [CNT_W-1:0]            cnt,
    input  logic [NWIN-1:0][CNT_W-1:0]  win_begin,
    input  logic [NWIN-1:0][CNT_W-1:0]  win_end,
    output logic [NWIN-1:0]             hit
);
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        assign hit[g] = (cnt >= win_begin[g]) && (cnt < win_end[g]);
    end
endmodule

// File: rtl/lstg_drive_reg.sv
module lstg_drive_reg
    import lstg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               armed,
    input  logic               ccd_mode,
    input  logic               reset_serial,
    input  logic [1:0]         tim_sel,
    input  logic [CNT_W-1:0]   xfer_len,
    input  logic [CNT_W-1:0]   cnt,
    input  logic               phase,
    input  logic               stb1,
    input  logic               stb2,
    input  logic               vld,
    input  logic [NUM_WIN-1:0] hit,
    output drive_t             d
);
    drive_t nxt;

    always_comb begin
        nxt.xfer  = ccd_mode ? (cnt < xfer_len) : (cnt == '0);
        nxt.phi1  = ccd_mode ? phase  : stb1;
        nxt.phi2  = ccd_mode ? ~phase : stb1;
        nxt.rclk1 = reset_serial ? stb1 : (stb1 & ~phase);
        nxt.rclk2 = reset_serial ? stb2 : (stb1 & phase);
        nxt.clamp = hit[WIN_CLAMP];
        nxt.gain  = hit[WIN_GAIN];
        nxt.sen   = pick_timing(tsel_e'(tim_sel), hit[WIN_CLAMP], hit[WIN_GAIN],
                                hit[WIN_USER], vld);
    end

    always_ff @(posedge clk) begin
        if (rst) d <= '0;
        else     d <= nxt;
    end

    // R6: CCD phase clocks never agree
    p_phase_compl_r6: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(ccd_mode)) |-> (d.phi1 != d.phi2));

    // R5: contact start pulse only from pixel 0
    p_start_once_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(ccd_mode) && d.xfer) |-> ($past(cnt) == '0));

    // R11: invalid line keeps the valid-only window closed
    p_valid_gate_r11: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(tim_sel) == 2'b11 && !$past(vld)) |-> !d.sen);

endmodule

// File: rtl/lstg_line_timer.sv
module lstg_line_timer
    import lstg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic             line_sync,
    input  logic             line_valid,
    input  logic             ccd_mode,
    input  logic             reset_serial,
    input  logic [1:0]       tim_sel,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic [CNT_W-1:0] clamp_begin,
    input  logic [CNT_W-1:0] clamp_end,
    input  logic [CNT_W-1:0] gain_begin,
    input  logic [CNT_W-1:0] gain_end,
    input  logic [CNT_W-1:0] user_begin,
    input  logic [CNT_W-1:0] user_end,
    output logic             xfer_o,
    output logic             phi1_o,
    output logic             phi2_o,
    output logic             rclk1_o,
    output logic             rclk2_o,
    output logic             clamp_o,
    output logic             gain_o,
    output logic             sen_tim_o
);
    logic [CNT_W-1:0]               cnt;
    logic                           phase, stb1, stb2, vld, armed;
    logic [NUM_WIN-1:0][CNT_W-1:0]  wb, we;
    logic [NUM_WIN-1:0]             hit;
    drive_t                         d;

    assign wb[WIN_CLAMP] = clamp_begin;
    assign we[WIN_CLAMP] = clamp_end;
    assign wb[WIN_GAIN]  = gain_begin;
    assign we[WIN_GAIN]  = gain_end;
    assign wb[WIN_USER]  = user_begin;
    assign we[WIN_USER]  = user_end;

    lstg_pix_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst(rst), .pix_en(pix_en), .line_sync(line_sync),
        .line_valid(line_valid), .cnt(cnt), .phase(phase), .stb1(stb1),
        .stb2(stb2), .vld(vld), .armed(armed)
    );

    lstg_win_bank #(.CNT_W(CNT_W), .NWIN(NUM_WIN)) i_win (
        .cnt(cnt), .win_begin(wb), .win_end(we), .hit(hit)
    );

    lstg_drive_reg #(.CNT_W(CNT_W)) i_drv (
        .clk(clk), .rst(rst), .armed(armed), .ccd_mode(ccd_mode),
        .reset_serial(reset_serial), .tim_sel(tim_sel), .xfer_len(xfer_len),
        .cnt(cnt), .phase(phase), .stb1(stb1), .stb2(stb2), .vld(vld),
        .hit(hit), .d(d)
    );

    assign xfer_o    = d.xfer;
    assign phi1_o    = d.phi1;
    assign phi2_o    = d.phi2;
    assign rclk1_o   = d.rclk1;
    assign rclk2_o   = d.rclk2;
    assign clamp_o   = d.clamp;
    assign gain_o    = d.gain;
    assign sen_tim_o = d.sen;
endmodule

// File: tb/test_lstg_line_timer.sv
module test_lstg_line_timer;
    localparam int CW   = 6;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1, pix_en = 1'b0, line_sync = 1'b0, line_valid = 1'b0;
    logic ccd_mode = 1'b0, reset_serial = 1'b0;
    logic [1:0] tim_sel = 2'b00;
    logic [CW-1:0] xfer_len = '0, clamp_begin = '0, clamp_end = '0;
    logic [CW-1:0] gain_begin = '0, gain_end = '0, user_begin = '0, user_end = '0;
    logic xfer_o, phi1_o, phi2_o, rclk1_o, rclk2_o, clamp_o, gain_o, sen_tim_o;

    lstg_line_timer #(.CNT_W(CW)) i_lstg_line_timer (
        .clk(clk), .rst(rst), .pix_en(pix_en), .line_sync(line_sync),
        .line_valid(line_valid), .ccd_mode(ccd_mode), .reset_serial(reset_serial),
        .tim_sel(tim_sel), .xfer_len(xfer_len), .clamp_begin(clamp_begin),
        .clamp_end(clamp_end), .gain_begin(gain_begin), .gain_end(gain_end),
        .user_begin(user_begin), .user_end(user_end), .xfer_o(xfer_o),
        .phi1_o(phi1_o), .phi2_o(phi2_o), .rclk1_o(rclk1_o), .rclk2_o(rclk2_o),
        .clamp_o(clamp_o), .gain_o(gain_o), .sen_tim_o(sen_tim_o)
    );

    int checks = 0, errors = 0;
    string win_tag = "R3";

    // Reference state, derived from the requirements.
    int m_cnt = MAXC, m_ph = 0, m_s1 = 0, m_s2 = 0, m_vld = 0;

    task automatic chk(input string req, input string name, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b (t=%0t)", req, name, act, exp, $time);
        end
    endtask

    function automatic logic in_win(input int b, input int e);
        return (m_cnt >= b) && (m_cnt < e);
    endfunction

    // One clock: predict outputs at the edge, compare at the following falling edge.
    task automatic step();
        logic e_x, e_p1, e_p2, e_r1, e_r2, e_c, e_g, e_u, e_s;
        @(posedge clk);
        if (rst) begin
            {e_x, e_p1, e_p2, e_r1, e_r2, e_c, e_g, e_s} = '0;
            m_cnt = MAXC; m_ph = 0; m_s1 = 0; m_s2 = 0; m_vld = 0;
        end else begin
            e_c  = in_win(clamp_begin, clamp_end);
            e_g  = in_win(gain_begin, gain_end);
            e_u  = in_win(user_begin, user_end);
            e_x  = ccd_mode ? (m_cnt < xfer_len) : (m_cnt == 0);
            e_p1 = ccd_mode ? logic'(m_ph)  : logic'(m_s1);
            e_p2 = ccd_mode ? !logic'(m_ph) : logic'(m_s1);
            e_r1 = reset_serial ? logic'(m_s1) : (m_s1 == 1 && m_ph == 0);
            e_r2 = reset_serial ? logic'(m_s2) : (m_s1 == 1 && m_ph == 1);
            case (tim_sel)
                2'b00:   e_s = e_c;
                2'b01:   e_s = e_g;
                2'b10:   e_s = e_u;
                default: e_s = e_u && (m_vld != 0);
            endcase
            m_s2 = m_s1;
            m_s1 = pix_en;
            if (pix_en) begin
                if (line_sync) begin
                    m_cnt = 0; m_ph = 0; m_vld = line_valid;
                end else begin
                    if (m_cnt < MAXC) m_cnt++;
                    m_ph = 1 - m_ph;
                end
            end
        end
        @(negedge clk);
        if (rst) begin
            chk("R1", "xfer",  xfer_o,  1'b0);
            chk("R1", "phi1",  phi1_o,  1'b0);
            chk("R1", "phi2",  phi2_o,  1'b0);
            chk("R1", "rclk1", rclk1_o, 1'b0);
            chk("R1", "rclk2", rclk2_o, 1'b0);
            chk("R1", "sen",   sen_tim_o, 1'b0);
        end else begin
            chk(ccd_mode ? "R4" : "R5", "xfer", xfer_o, e_x);
            chk(ccd_mode ? "R6" : "R7", "phi1", phi1_o, e_p1);
            chk(ccd_mode ? "R6" : "R7", "phi2", phi2_o, e_p2);
            chk(reset_serial ? "R9" : "R8", "rclk1", rclk1_o, e_r1);
            chk(reset_serial ? "R9" : "R8", "rclk2", rclk2_o, e_r2);
            chk(win_tag, "clamp", clamp_o, e_c);
            chk(win_tag, "gain",  gain_o,  e_g);
            chk(tim_sel == 2'b11 ? "R11" : "R10", "sen", sen_tim_o, e_s);
        end
        clamp_begin = clamp_begin; // inputs change only between steps
    endtask

    task automatic run_line(input int n);
        pix_en = 1'b1; line_sync = 1'b1;
        step();
        line_sync = 1'b0;
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) step();
        rst = 1'b0;
        clamp_begin = 6'd2;  clamp_end = 6'd6;
        gain_begin  = 6'd5;  gain_end  = 6'd12;
        user_begin  = 6'd10; user_end  = 6'd20;
        xfer_len = 6'd3;
        ccd_mode = 1'b1; reset_serial = 1'b0; tim_sel = 2'b00; line_valid = 1'b1;
        pix_en = 1'b1;
        repeat (4) step();           // before any sync: count held at maximum
        // CCD, parallel reset, clamp window, long line into saturation
        run_line(70);
        // contact sensor, serial reset, gain window, line long enough to saturate
        ccd_mode = 1'b0; reset_serial = 1'b1; tim_sel = 2'b01;
        run_line(68);
        // CCD, serial reset, user window on all lines
        ccd_mode = 1'b1; tim_sel = 2'b10;
        run_line(25);
        // R11: valid-only window, valid line then invalid line with late valid
        tim_sel = 2'b11; line_valid = 1'b1;
        run_line(25);
        line_valid = 1'b0;
        pix_en = 1'b1; line_sync = 1'b1;
        step();
        line_sync = 1'b0;
        for (int i = 0; i < 25; i++) begin
            if (i == 3) line_valid = 1'b1;
            step();
        end
        // R2: gated pixel enables, contact serial
        win_tag = "R2";
        ccd_mode = 1'b0; reset_serial = 1'b1; tim_sel = 2'b00;
        for (int i = 0; i < 60; i++) begin
            pix_en    = (i % 2 == 0);
            line_sync = (i == 0);
            step();
        end
        // R2: irregular enables, CCD parallel
        ccd_mode = 1'b1; reset_serial = 1'b0; tim_sel = 2'b01;
        for (int i = 0; i < 60; i++) begin
            pix_en    = (i % 3 != 1);
            line_sync = (i == 0);
            step();
        end
        // irregular enables, contact parallel
        ccd_mode = 1'b0;
        for (int i = 0; i < 40; i++) begin
            pix_en    = (i % 4 != 3);
            line_sync = (i == 0);
            step();
        end
        // R4 / R3 boundaries: zero transfer length, empty user window
        win_tag = "R3";
        ccd_mode = 1'b1; xfer_len = 6'd0; tim_sel = 2'b10;
        user_begin = 6'd7; user_end = 6'd7;
        run_line(12);
        // full-width windows touching the count limit
        xfer_len = 6'd63; clamp_begin = 6'd0; clamp_end = 6'd63;
        run_line(66);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule